// File: doc/BRIEF.md
# Poly1305 Tag Engine

This block computes a 16-byte Poly1305 one-time authentication tag. A 32-byte one-time key is loaded first: the low half is clamped into the multiplier r and the high half is kept as the final offset s. The message then arrives as a stream of 16-byte blocks. Each block is padded with a 0x01 marker byte, added into a 130-bit accumulator, and multiplied by r modulo 2^130-5. The last block may be short; its byte count says how many of its low bytes are message.

The multiplication is bit-serial over the 128 bits of r and takes 128 cycles per block. There is no divider. Every partial result is brought back below 2^131 by taking the bits at 2^130 and above, multiplying them by 5 with a shift and an add, and adding them back to the low bits. After the last block one conditional subtraction of the prime fully reduces the accumulator. Then s is added and the low 128 bits are the tag. The engine pulses `tag_valid` and returns to idle, ready for a new key.

Top module: `p1305_tagger`

## Requirements
- R1: r is key bytes 0..15, read little-endian, with key byte i on `key_data[8i+7:8i]`, ANDed with 0x0ffffffc0ffffffc0ffffffc0fffffff.
- R2: s is key bytes 16..31, read little-endian. The tag is (fully reduced accumulator + s) mod 2^128, and tag byte i appears on `tag_data[8i+7:8i]`.
- R3: The accumulator is zero after a key is accepted. For each block n, the new accumulator is ((acc + n) * r) mod (2^130-5). A full block n is its 16 bytes read little-endian (byte i on `blk_data[8i+7:8i]`) plus 2^128.
- R4: On a block with `blk_last`=1 and `blk_bytes`=k, where 1<=k<=15, byte k of n is 0x01 and bytes above k are zero, whatever `blk_data` holds there.
- R5: `blk_bytes` has no effect on a block with `blk_last`=0, or when it is 0 or at least 16. Such a block is taken as a full 16-byte block.
- R6: The tag is exact for every accumulator value, including runs of all-ones blocks with the largest clamped r. Reduction uses only shifts, adds and one conditional subtraction.
- R7: `key_ready` is high only when idle. `blk_ready` is high in the cycle after a key handshake. After a block handshake, `blk_ready` stays low for exactly 128 cycles.
- R8: `tag_valid` rises 129 cycles after the last-block handshake and lasts one cycle. `key_ready` is high while it is high.
- R9: After synchronous reset: `key_ready`=1, `blk_ready`=0, `tag_valid`=0, `tag_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-time key offered |
| key_ready | output | 1 | Engine idle, key accepted when valid |
| key_data | input | 256 | Key, byte i on bits 8i+7:8i |
| blk_valid | input | 1 | Message block offered |
| blk_ready | output | 1 | Engine waiting for a block |
| blk_data | input | 128 | Block bytes, byte i on bits 8i+7:8i |
| blk_bytes | input | 5 | Byte count of a short final block |
| blk_last | input | 1 | Marks the final block of the message |
| tag_valid | output | 1 | One-cycle tag strobe |
| tag_data | output | 128 | Tag, byte i on bits 8i+7:8i |

## Verification
A published 34-byte message with a known tag checks the byte order, the padding of the short last block and the whole arithmetic against an outside reference. All-ones blocks with all-ones keys push the partial results and the accumulator as high as they can go, so a fold or final subtraction that is off by one bit gives a wrong tag. Short final blocks with junk above the count separate correct marker placement from plain masking. Non-final blocks carrying odd counts, and final blocks with counts of 0 or 16 and above, show whether the count is ignored where it should be. Random keys, lengths and counts then exercise the engine broadly, while the gap from each handshake to the next ready or tag strobe is counted.

// File: rtl/p1305_pkg.sv
package p1305_pkg;
  localparam int BLK_BYTES  = 16;
  localparam int BLK_W      = 8 * BLK_BYTES;
  localparam int KEY_W      = 2 * BLK_W;
  localparam int CNT_W      = $clog2(BLK_BYTES + 1);
  localparam int LIMB_W     = 130;
  localparam int ACC_W      = LIMB_W + 1;
  localparam int SUM_W      = ACC_W + 1;
  localparam int STEP_SUM_W = ACC_W + 2;
  localparam int MUL_STEPS  = BLK_W;
  localparam int STEP_W     = $clog2(MUL_STEPS);

  localparam logic [LIMB_W-1:0] PRIME      = {LIMB_W{1'b1}} - LIMB_W'(4);
  localparam logic [BLK_W-1:0]  CLAMP_MASK = 128'h0ffffffc0ffffffc0ffffffc0fffffff;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ABSORB,
    ST_MUL,
    ST_FINISH
  } eng_state_t;
endpackage

// File: rtl/p1305_pad.sv
module p1305_pad
  import p1305_pkg::*;
(
  input  logic [BLK_W-1:0] data,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             last,
  output logic [BLK_W:0]   padded
);
  logic [CNT_W-1:0] eff;

  always_comb begin
    if (last && nbytes != '0 && nbytes < CNT_W'(BLK_BYTES)) eff = nbytes;
    else eff = CNT_W'(BLK_BYTES);
  end

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
    assign padded[8*i +: 8] = (CNT_W'(i) < eff) ? data[8*i +: 8] :
                              (CNT_W'(i) == eff) ? 8'h01 : 8'h00;
  end
  assign padded[BLK_W] = (eff == CNT_W'(BLK_BYTES));
endmodule

// File: rtl/p1305_fold.sv
module p1305_fold #(
  parameter int IN_W   = 133,
  parameter int LIMB_W = 130,
  parameter int OUT_W  = 131
) (
  input  logic [IN_W-1:0]  x,
  output logic [OUT_W-1:0] y
);
  localparam int W = OUT_W + 1;
  logic [W-1:0] hi_ext;
  logic [W-1:0] sum_w;

  always_comb begin
    hi_ext = W'(x[IN_W-1:LIMB_W]);
    sum_w  = W'(x[LIMB_W-1:0]) + (hi_ext << 2) + hi_ext;
  end
  assign y = sum_w[OUT_W-1:0];

  always_comb begin
    // R6
    no_fold_ovf_chk: assert (sum_w[OUT_W] == 1'b0)
      else $error("fold result does not fit");
  end
endmodule

// File: rtl/p1305_final.sv
module p1305_final
  import p1305_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  logic [BLK_W-1:0] s,
  output logic [BLK_W-1:0] tag
);
  logic [ACC_W-1:0] folded;
  logic [ACC_W-1:0] red;

  p1305_fold #(.IN_W(ACC_W), .LIMB_W(LIMB_W), .OUT_W(ACC_W)) u_fold (
    .x (acc),
    .y (folded)
  );

  always_comb begin
    if (folded >= ACC_W'(PRIME)) red = folded - ACC_W'(PRIME);
    else red = folded;
  end

  assign tag = red[BLK_W-1:0] + s;

  always_comb begin
    // R6
    red_below_p_chk: assert (red < ACC_W'(PRIME))
      else $error("final value not fully reduced");
  end
endmodule

// File: rtl/p1305_tagger.sv
module p1305_tagger
  import p1305_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key_data,
  input  logic             blk_valid,
  output logic             blk_ready,
  input  logic [BLK_W-1:0] blk_data,
  input  logic [CNT_W-1:0] blk_bytes,
  input  logic             blk_last,
  output logic             tag_valid,
  output logic [BLK_W-1:0] tag_data
);
  eng_state_t             st_q;
  logic [BLK_W-1:0]       r_q, s_q;
  logic [ACC_W-1:0]       acc_q, a_q, p_q;
  logic [STEP_W-1:0]      cnt_q;
  logic                   last_q;

  logic [BLK_W:0]         padded;
  logic [SUM_W-1:0]       absorb_sum;
  logic [ACC_W-1:0]       absorb_fold;
  logic [STEP_SUM_W-1:0]  step_sum;
  logic [ACC_W-1:0]       step_fold;
  logic [BLK_W-1:0]       tag_w;

  assign key_ready = (st_q == ST_IDLE);
  assign blk_ready = (st_q == ST_ABSORB);

  p1305_pad u_pad (
    .data   (blk_data),
    .nbytes (blk_bytes),
    .last   (blk_last),
    .padded (padded)
  );

  assign absorb_sum = SUM_W'(acc_q) + SUM_W'(padded);

  p1305_fold #(.IN_W(SUM_W), .LIMB_W(LIMB_W), .OUT_W(ACC_W)) u_fold_abs (
    .x (absorb_sum),
    .y (absorb_fold)
  );

  // Horner step, most significant bit of r first: p = 2p + bit*a
  assign step_sum = STEP_SUM_W'({p_q, 1'b0}) +
                    (r_q[cnt_q] ? STEP_SUM_W'(a_q) : '0);

  p1305_fold #(.IN_W(STEP_SUM_W), .LIMB_W(LIMB_W), .OUT_W(ACC_W)) u_fold_mul (
    .x (step_sum),
    .y (step_fold)
  );

  p1305_final u_final (
    .acc (acc_q),
    .s   (s_q),
    .tag (tag_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      r_q       <= '0;
      s_q       <= '0;
      acc_q     <= '0;
      a_q       <= '0;
      p_q       <= '0;
      cnt_q     <= '0;
      last_q    <= 1'b0;
      tag_valid <= 1'b0;
      tag_data  <= '0;
    end else begin
      tag_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (key_valid) begin
            r_q   <= key_data[BLK_W-1:0] & CLAMP_MASK;
            s_q   <= key_data[KEY_W-1:BLK_W];
            acc_q <= '0;
            st_q  <= ST_ABSORB;
          end
        end
        ST_ABSORB: begin
          if (blk_valid) begin
            a_q    <= absorb_fold;
            p_q    <= '0;
            cnt_q  <= STEP_W'(MUL_STEPS - 1);
            last_q <= blk_last;
            st_q   <= ST_MUL;
          end
        end
        ST_MUL: begin
          p_q <= step_fold;
          if (cnt_q == '0) begin
            acc_q <= step_fold;
            st_q  <= last_q ? ST_FINISH : ST_ABSORB;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          tag_data  <= tag_w;
          tag_valid <= 1'b1;
          st_q      <= ST_IDLE;
        end
      endcase
    end
  end

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({key_ready, blk_ready}));
  // R7
  key_then_blk_chk: assert property (@(posedge clk) disable iff (rst)
    (key_valid && key_ready) |=> blk_ready);
  // R7
  blk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_ready) |=> !blk_ready);
  // R8
  tag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tag_valid |=> !tag_valid);
  // R8
  tag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tag_valid |-> key_ready);
endmodule

// File: tb/p1305_tagger_test.sv
module p1305_tagger_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         key_valid, key_ready;
  logic [255:0] key_data;
  logic         blk_valid, blk_ready;
  logic [127:0] blk_data;
  logic [4:0]   blk_bytes;
  logic         blk_last;
  logic         tag_valid;
  logic [127:0] tag_data;

  logic [127:0] msg [0:7];
  logic [4:0]   fld [0:7];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  p1305_tagger uut (
    .clk(clk), .rst(rst),
    .key_valid(key_valid), .key_ready(key_ready), .key_data(key_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .blk_bytes(blk_bytes), .blk_last(blk_last),
    .tag_valid(tag_valid), .tag_data(tag_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_tag(input logic [255:0] key, input int nb);
    logic [261:0] p, r, acc, val;
    int eff;
    p   = (262'd1 << 130) - 262'd5;
    r   = 262'(key[127:0] & 128'h0ffffffc0ffffffc0ffffffc0fffffff);
    acc = '0;
    for (int i = 0; i < nb; i++) begin
      eff = 16;
      if (i == nb - 1 && fld[i] >= 5'd1 && fld[i] <= 5'd15) eff = int'(fld[i]);
      val = '0;
      for (int b = 0; b < eff; b++) val[8*b +: 8] = msg[i][8*b +: 8];
      val[8*eff +: 8] = 8'h01;
      acc = ((acc + val) * r) % p;
    end
    acc = acc + 262'(key[255:128]);
    return acc[127:0];
  endfunction

  task automatic run_msg(input logic [255:0] key, input int nb, input string req);
    int cyc;
    logic [127:0] exp;
    exp = model_tag(key, nb);
    @(negedge clk);
    key_valid = 1'b1;
    key_data  = key;
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 1'b0;
    chk("R7 blk_ready after key", 128'(blk_ready), 128'd1);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      blk_valid = 1'b1;
      blk_data  = msg[i];
      blk_bytes = fld[i];
      blk_last  = (i == nb - 1);
      while (!blk_ready) @(negedge clk);
      @(negedge clk);
      blk_valid = 1'b0;
      blk_data  = {4{$urandom}};
      cyc = 0;
      if (i < nb - 1) begin
        while (!blk_ready) begin @(negedge clk); cyc++; end
        chk("R7 block gap", 128'(cyc), 128'd128);
      end else begin
        while (!tag_valid) begin @(negedge clk); cyc++; end
        chk("R8 tag latency", 128'(cyc), 128'd129);
        chk(req, tag_data, exp);
        chk("R8 key_ready with tag", 128'(key_ready), 128'd1);
        @(negedge clk);
        chk("R8 tag pulse", 128'(tag_valid), 128'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    string m;
    int nb;
    logic [255:0] k;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    key_valid = 1'b0; key_data = '0;
    blk_valid = 1'b0; blk_data = '0; blk_bytes = '0; blk_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 key_ready", 128'(key_ready), 128'd1);
    chk("R9 blk_ready", 128'(blk_ready), 128'd0);
    chk("R9 tag_valid", 128'(tag_valid), 128'd0);
    chk("R9 tag_data", tag_data, 128'd0);

    // Published vector: 34-byte text, short last block of 2 bytes (R4)
    m = "Cryptographic Forum Research Group";
    for (int i = 0; i < 8; i++) begin msg[i] = '0; fld[i] = 5'd16; end
    for (int b = 0; b < 34; b++) msg[b/16][8*(b%16) +: 8] = m[b];
    fld[2] = 5'd2;
    k = 256'h1bf54941aff6bf4afdb20dfb8a800301a806d542fe52447f336d555778bed685;
    chk("R4 model vs known tag", model_tag(k, 3), 128'ha927010caf8b2bc2c6365130c11d06a8);
    run_msg(k, 3, "R4 known vector");

    // All-ones key and block: clamp of r (R1)
    msg[0] = '1; fld[0] = 5'd16;
    run_msg('1, 1, "R1 clamp all-ones key");

    // Large s with carry out of bit 127 (R2)
    msg[0] = 128'h0123456789abcdef0011223344556677; fld[0] = 5'd16;
    run_msg({128'hffffffffffffffffffffffffffffff00, 128'h3}, 1, "R2 s add truncation");

    // Many all-ones blocks with max clamped r (R6)
    for (int i = 0; i < 8; i++) begin msg[i] = '1; fld[i] = 5'd16; end
    run_msg({128'h5, 128'hffffffffffffffffffffffffffffffff}, 8, "R6 maximal accumulator");

    // Short last block of 1 byte with junk above (R4)
    msg[0] = {4{32'hdeadbeef}}; fld[0] = 5'd1;
    run_msg({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
            1, "R4 one-byte last block");
    msg[0] = {4{32'hcafef00d}}; fld[0] = 5'd15;
    run_msg({8{32'h13579bdf}}, 1, "R4 fifteen-byte last block");

    // Counts ignored on non-last blocks and out-of-range on last (R5)
    msg[0] = {4{32'h11111111}}; fld[0] = 5'd3;
    msg[1] = {4{32'h22222222}}; fld[1] = 5'd7;
    msg[2] = {4{32'h33333333}}; fld[2] = 5'd0;
    run_msg({8{32'h2468ace0}}, 3, "R5 counts ignored, last count 0");
    msg[0] = {4{32'h44444444}}; fld[0] = 5'd31;
    run_msg({8{32'h0f1e2d3c}}, 1, "R5 last count 31");
    msg[0] = {4{32'h55555555}}; fld[0] = 5'd16;
    run_msg({8{32'h89abcdef}}, 1, "R5 last count 16");

    // Random messages (R3)
    for (int t = 0; t < 12; t++) begin
      nb = $urandom_range(1, 8);
      for (int i = 0; i < 8; i++) begin
        msg[i] = {$urandom, $urandom, $urandom, $urandom};
        fld[i] = 5'($urandom_range(0, 31));
      end
      run_msg({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
              nb, "R3 random message");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule